// File: doc/BRIEF.md
# SMBus Packet Error Check Unit

This block keeps the 8-bit SMBus packet error code for one I2C transaction. The byte engine of the link strobes each byte that crosses the bus (address byte first, then data) together with a direction flag, and the unit folds that byte into a running CRC in a single cycle. The CRC restarts from zero on every START or repeated START.

At the end of a packet the controller opens a PEC slot. In manual mode it does this with a one-cycle request. In DMA mode the request is a level, and the slot opens when the DMA byte count reports zero. In transmit direction the unit then presents the computed CRC as the byte to send. In receive direction it compares the next received byte with the computed CRC. A mismatch raises a sticky error flag that the host clears. The byte that fills the slot is never folded into the CRC.

Top module: `smbpec_unit`

## Requirements
- R1: The CRC uses the polynomial 0x07 (x^8+x^2+x+1), starts at 0x00 and consumes each byte MSB first. The whole byte is folded in the cycle its strobe is sampled, and `crc_out` shows the result one clock later. As examples, the byte 0x01 alone gives 0x07 and the ASCII string "123456789" gives 0xF4.
- R2: While enabled and outside a PEC slot, every strobed byte is folded in, including the first byte after START (the address byte). There is no distinction by direction.
- R3: `start_det` forces the CRC to 0x00 and closes any open slot. It overrides a byte strobe in the same cycle and acts even while disabled. After reset the CRC is 0x00, no slot is open and `pec_err` is low.
- R4: In manual mode (`dma_mode`=0) a cycle with `pec_req` high opens a slot. `dir_tx`=1 means transmit and `dir_tx`=0 means receive. While a transmit slot is open, `pec_tx_byte` equals `crc_out`. Otherwise `pec_tx_byte` is 0x00. `pec_slot` is high while any slot is open.
- R5: The byte that fills an open slot leaves the CRC unchanged and closes the slot on the next clock.
- R6: In a receive slot, the slot byte is compared with the CRC. A differing byte sets `pec_err` and an equal byte leaves it unchanged. Transmit slot bytes are never compared.
- R7: `pec_err` stays set until `err_clr` is high. If a mismatch and `err_clr` occur in the same cycle, the flag ends set.
- R8: In DMA mode (`dma_mode`=1), `pec_req` acts as a level. A slot opens only in a cycle where `dma_last` is high while `pec_req` is high. `pec_req` by itself opens nothing.
- R9: With `pec_en` low, strobed bytes leave the CRC unchanged, requests open no slot, and an open slot is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pec_en | input | 1 | Enables CRC folding and slots |
| start_det | input | 1 | START or repeated START seen |
| byte_vld | input | 1 | Byte strobe |
| byte_data | input | 8 | Byte on the bus |
| dir_tx | input | 1 | 1 = transmit, 0 = receive |
| dma_mode | input | 1 | Selects DMA-driven slot opening |
| pec_req | input | 1 | PEC transfer request (pulse or level) |
| dma_last | input | 1 | DMA byte count reached zero |
| err_clr | input | 1 | Clears the sticky error |
| crc_out | output | 8 | Current CRC |
| pec_tx_byte | output | 8 | Byte to send in a transmit slot |
| pec_slot | output | 1 | A PEC slot is open |
| pec_err | output | 1 | Sticky PEC mismatch |

## Verification
A corrupt CRC register shows on `crc_out` one clock after the faulty strobe. It also shows through `pec_tx_byte` in a transmit slot, and as a wrong `pec_err` after a receive slot. A slot state that is wrong appears on `pec_slot` in the cycle after the request or the slot byte. It also shows as a slot byte being folded in, which `crc_out` exposes one clock later. Each scoreboard item is compared one clock after its stimulus, so a divergence is reported in the cycle it first appears.

// File: rtl/smbpec_pkg.sv
package smbpec_pkg;

    localparam int unsigned CRC_W   = 8;
    localparam logic [7:0]  PEC_POLY = 8'h07;

    typedef logic [CRC_W-1:0] crc_t;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_TX   = 2'd1,
        SLOT_RX   = 2'd2
    } slot_e;

    typedef struct packed {
        logic start;
        logic vld;
        crc_t data;
    } bus_ev_t;

    function automatic logic slot_open(slot_e s);
        return s != SLOT_IDLE;
    endfunction

endpackage

// File: rtl/smbpec_fold.sv
module smbpec_fold #(
    parameter int unsigned W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] c_in,
    input  logic [W-1:0] data,
    output logic [W-1:0] c_out
);
    logic [W-1:0] stage [0:W];

    assign stage[0] = c_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic fb;
        assign fb           = stage[i][W-1] ^ data[W-1-i];
        assign stage[i+1]   = {stage[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign c_out = stage[W];
endmodule

// File: rtl/smbpec_crc_reg.sv
module smbpec_crc_reg
    import smbpec_pkg::*;
#(
    parameter int unsigned W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         fold,
    input  logic [W-1:0] data,
    output logic [W-1:0] crc_q
);
    logic [W-1:0] crc_nx;

    smbpec_fold #(.W(W), .POLY(W'(PEC_POLY))) u_fold (
        .c_in  (crc_q),
        .data  (data),
        .c_out (crc_nx)
    );

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc_q <= '0;
        else if (fold)
            crc_q <= crc_nx;
    end
endmodule

// File: rtl/smbpec_slot.sv
module smbpec_slot
    import smbpec_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  start,
    input  logic  arm,
    input  logic  dir_tx,
    input  logic  consume,
    output slot_e state
);
    slot_e state_nx;

    always_comb begin
        state_nx = state;
        if (start || !en) begin
            state_nx = SLOT_IDLE;
        end else begin
            case (state)
                SLOT_IDLE: if (arm) state_nx = dir_tx ? SLOT_TX : SLOT_RX;
                SLOT_TX,
                SLOT_RX:   if (consume) state_nx = SLOT_IDLE;
                default:   state_nx = SLOT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SLOT_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/smbpec_check.sv
module smbpec_check
    import smbpec_pkg::*;
#(
    parameter int unsigned W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cmp,
    input  logic [W-1:0] rx_byte,
    input  logic [W-1:0] crc_q,
    input  logic         clr,
    output logic         err_q
);
    logic miss;
    assign miss = cmp && (rx_byte != crc_q);

    always_ff @(posedge clk) begin
        if (rst)       err_q <= 1'b0;
        else if (miss) err_q <= 1'b1;
        else if (clr)  err_q <= 1'b0;
    end
endmodule

// File: rtl/smbpec_unit.sv
module smbpec_unit
    import smbpec_pkg::*;
#(
    parameter int unsigned W = CRC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pec_en,
    input  logic         start_det,
    input  logic         byte_vld,
    input  logic [W-1:0] byte_data,
    input  logic         dir_tx,
    input  logic         dma_mode,
    input  logic         pec_req,
    input  logic         dma_last,
    input  logic         err_clr,
    output logic [W-1:0] crc_out,
    output logic [W-1:0] pec_tx_byte,
    output logic         pec_slot,
    output logic         pec_err
);
    slot_e  slot_st;
    logic   live, idle, arm, fold, cmp;

    assign live = pec_en && !start_det;
    assign idle = (slot_st == SLOT_IDLE);
    assign arm  = pec_en && (dma_mode ? (pec_req && dma_last) : pec_req);
    assign fold = live && byte_vld && idle;
    assign cmp  = live && byte_vld && (slot_st == SLOT_RX);

    smbpec_crc_reg #(.W(W)) u_crc (
        .clk   (clk),
        .rst   (rst),
        .clr   (start_det),
        .fold  (fold),
        .data  (byte_data),
        .crc_q (crc_out)
    );

    smbpec_slot u_slot (
        .clk     (clk),
        .rst     (rst),
        .en      (pec_en),
        .start   (start_det),
        .arm     (arm),
        .dir_tx  (dir_tx),
        .consume (byte_vld),
        .state   (slot_st)
    );

    smbpec_check #(.W(W)) u_chk_err (
        .clk     (clk),
        .rst     (rst),
        .cmp     (cmp),
        .rx_byte (byte_data),
        .crc_q   (crc_out),
        .clr     (err_clr),
        .err_q   (pec_err)
    );

    assign pec_slot    = slot_open(slot_st);
    assign pec_tx_byte = (slot_st == SLOT_TX) ? crc_out : '0;
endmodule

// File: rtl/smbpec_unit_chk.sv
module smbpec_unit_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         pec_en,
    input logic         start_det,
    input logic         byte_vld,
    input logic         err_clr,
    input logic [W-1:0] crc_out,
    input logic [W-1:0] pec_tx_byte,
    input logic         pec_slot,
    input logic         pec_err
);
    // R3
    a_r3_start_clears: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (crc_out == '0) && !pec_slot);
    // R9
    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!pec_en && !start_det) |=> $stable(crc_out) && !pec_slot);
    // R5
    a_r5_slot_closes: assert property (@(posedge clk) disable iff (rst)
        (pec_slot && byte_vld && pec_en && !start_det) |=> !pec_slot && $stable(crc_out));
    // R7
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (pec_err && !err_clr) |=> pec_err);
    // R6
    a_r6_err_from_slot: assert property (@(posedge clk) disable iff (rst)
        $rose(pec_err) |-> $past(pec_slot && byte_vld));
    // R4
    a_r4_tx_byte_in_slot: assert property (@(posedge clk) disable iff (rst)
        (pec_tx_byte != '0) |-> pec_slot);
endmodule

bind smbpec_unit smbpec_unit_chk #(.W(W)) u_sva (
    .clk         (clk),
    .rst         (rst),
    .pec_en      (pec_en),
    .start_det   (start_det),
    .byte_vld    (byte_vld),
    .err_clr     (err_clr),
    .crc_out     (crc_out),
    .pec_tx_byte (pec_tx_byte),
    .pec_slot    (pec_slot),
    .pec_err     (pec_err)
);

// File: tb/smbpec_unit_tb.sv
`timescale 1ns/1ps
module smbpec_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pec_en = 1'b0, start_det = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic       dir_tx = 1'b0, dma_mode = 1'b0, pec_req = 1'b0;
    logic       dma_last = 1'b0, err_clr = 1'b0;
    logic [7:0] crc_out, pec_tx_byte;
    logic       pec_slot, pec_err;

    always #2 clk = ~clk;

    smbpec_unit u_dut (
        .clk(clk), .rst(rst), .pec_en(pec_en), .start_det(start_det),
        .byte_vld(byte_vld), .byte_data(byte_data), .dir_tx(dir_tx),
        .dma_mode(dma_mode), .pec_req(pec_req), .dma_last(dma_last),
        .err_clr(err_clr), .crc_out(crc_out), .pec_tx_byte(pec_tx_byte),
        .pec_slot(pec_slot), .pec_err(pec_err)
    );

    typedef struct {
        logic [7:0] crc;
        logic [7:0] txb;
        logic       slot;
        logic       err;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;

    logic [7:0] m_crc = 8'h00;
    int         m_slot = 0;   // 0 none, 1 tx, 2 rx
    logic       m_err = 1'b0;

    function automatic logic [7:0] ref_crc(logic [7:0] c, logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int k = 0; k < 8; k++)
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic cyc(input logic st, input logic v, input logic [7:0] d,
                       input logic rq, input logic dl, input logic cl,
                       input string tag);
        exp_t e;
        logic set;
        start_det = st; byte_vld = v; byte_data = d;
        pec_req = rq; dma_last = dl; err_clr = cl;
        set = 1'b0;
        if (st) m_crc = 8'h00;
        if (st || !pec_en) begin
            m_slot = 0;
        end else if (m_slot == 0) begin
            if (v) m_crc = ref_crc(m_crc, d);
            if (dma_mode ? (rq && dl) : rq) m_slot = dir_tx ? 1 : 2;
        end else if (v) begin
            if (m_slot == 2 && d != m_crc) set = 1'b1;
            m_slot = 0;
        end
        if (set) m_err = 1'b1;
        else if (cl) m_err = 1'b0;
        e.crc = m_crc; e.slot = (m_slot != 0);
        e.txb = (m_slot == 1) ? m_crc : 8'h00;
        e.err = m_err; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 8'h00, 0, 0, 0, tag);
    endtask

    task automatic put(input logic [7:0] d, input string tag);
        cyc(0, 1, d, 0, 0, 0, tag);
    endtask

    // monitor: compares one item per clock, 1 ns after the edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (crc_out !== e.crc || pec_tx_byte !== e.txb ||
                pec_slot !== e.slot || pec_err !== e.err) begin
                n_err++;
                $display("FAIL %s: crc=%h txb=%h slot=%b err=%b expected crc=%h txb=%h slot=%b err=%b",
                         e.tag, crc_out, pec_tx_byte, pec_slot, pec_err,
                         e.crc, e.txb, e.slot, e.err);
            end
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        string s;
        s = "123456789";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle("R3 reset state");

        pec_en = 1'b1; dir_tx = 1'b0;
        cyc(1, 0, 8'h00, 0, 0, 0, "R3 start");
        put(8'h01, "R1 single byte 0x01");
        cyc(1, 0, 8'h00, 0, 0, 0, "R3 repeated start");
        for (int i = 0; i < 9; i++) put(s[i], "R1 R2 check string");
        idle("R1 string crc F4");
        cyc(1, 1, 8'hAA, 0, 0, 0, "R3 start beats byte");

        // transmit slot, manual
        dir_tx = 1'b1;
        put(8'hA4, "R2 address byte folded");
        put(8'h3C, "R2 data byte");
        cyc(0, 0, 8'h00, 1, 0, 0, "R4 open tx slot");
        idle("R4 tx byte shown");
        put(8'h77, "R5 tx slot byte not folded");
        put(8'h10, "R2 folding resumes");

        // receive slot, match then mismatch
        dir_tx = 1'b0;
        cyc(1, 0, 8'h00, 0, 0, 0, "R3 start rx");
        put(8'hA5, "R2 rx address");
        put(8'h42, "R2 rx data");
        cyc(0, 0, 8'h00, 1, 0, 0, "R4 open rx slot");
        put(m_crc, "R6 matching pec");
        cyc(0, 0, 8'h00, 1, 0, 0, "R4 reopen rx slot");
        put(m_crc ^ 8'h01, "R6 mismatching pec");
        idle("R7 error held");
        put(8'h33, "R7 error held over bytes");
        cyc(0, 0, 8'h00, 0, 0, 1, "R7 error cleared");
        cyc(0, 0, 8'h00, 1, 0, 0, "R4 open rx slot again");
        cyc(0, 1, m_crc ^ 8'hFF, 0, 0, 1, "R7 set wins over clear");
        cyc(0, 0, 8'h00, 0, 0, 1, "R7 clear");

        // DMA mode
        dma_mode = 1'b1; dir_tx = 1'b1;
        cyc(1, 0, 8'h00, 1, 0, 0, "R8 start dma");
        cyc(0, 1, 8'hC3, 1, 0, 0, "R8 level req alone no slot");
        cyc(0, 1, 8'h5E, 1, 0, 0, "R8 level req alone no slot 2");
        cyc(0, 0, 8'h00, 1, 1, 0, "R8 count zero opens slot");
        cyc(0, 1, 8'h00, 1, 0, 0, "R8 R5 dma slot consumed");
        cyc(0, 0, 8'h00, 1, 0, 0, "R8 no reopen");
        dir_tx = 1'b0;
        cyc(0, 0, 8'h00, 1, 1, 0, "R8 rx slot via dma");
        cyc(0, 1, 8'h99, 1, 0, 0, "R8 R6 dma rx check");
        cyc(0, 0, 8'h00, 0, 0, 1, "R7 clear after dma");
        dma_mode = 1'b0;

        // disabled
        cyc(0, 0, 8'h00, 1, 0, 0, "R4 slot before disable");
        pec_en = 1'b0;
        idle("R9 slot dropped when disabled");
        put(8'h12, "R9 byte ignored");
        cyc(0, 0, 8'h00, 1, 0, 0, "R9 request ignored");
        cyc(1, 0, 8'h00, 0, 0, 0, "R3 start while disabled");
        put(8'hFE, "R9 byte ignored after start");
        pec_en = 1'b1;
        put(8'h01, "R1 resumes from zero");
        idle("R1 final");
        idle("drain");
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule